// File: doc/BRIEF.md
# Multi-Target Serial Peripheral Master

This block is a serial peripheral bus master that runs full-duplex transfers to one of several attached targets. Each target has its own active-low select line. A small set of registers holds a clock polarity and a clock phase for every target, plus a clock divider. A host starts a transfer by presenting a target index, a transmit word and a length code on a parallel request port.

At the start of each transfer the master loads the mode stored for the chosen target. It first moves the serial clock to that target's idle level and only then pulls the select low. It shifts the word out most-significant bit first while it captures the incoming line. When the frame is done it releases the select and returns the received word with a one-cycle done pulse.

The frame length can be 8, 16 or 32 bits and is chosen on every request. Requests that arrive while a transfer is running are dropped.

Top module: `spi_multi_master`

## Requirements
- R1: After a synchronous active-low reset all select lines are high, and busy, done, sclk, mosi and rx_data are all zero.
- R2: At most one select line is low at any time, and it is the line whose index was given with the accepted request.
- R3: When a select line goes low, sclk has already been at the stored polarity of that target for at least one system cycle, and sclk does not change in that same cycle.
- R4: With phase 0, both data lines are sampled on the first sclk edge of each bit and mosi changes on the second edge. The first bit is on mosi before the first edge. With phase 1, mosi changes on the first edge and both lines are sampled on the second edge.
- R5: Data is shifted most-significant bit first in both directions at the same time. rx_data holds the captured bits right-aligned, and its upper bits are zero for frames shorter than 32 bits.
- R6: The length code sets the number of bits per frame: 2'b00 gives 8, 2'b01 gives 16, and 2'b10 or 2'b11 gives 32. A frame has exactly twice that many sclk edges.
- R7: Successive sclk edges are DIV+1 system cycles apart, so one serial clock period is 2*(DIV+1) system cycles. DIV is the value in the divider register when the request is accepted.
- R8: The first sclk edge comes DIV+1 system cycles after the select goes low. The select goes high DIV+1 system cycles after the last edge.
- R9: busy is high from the cycle after a request is accepted until the select is released. A request presented while busy is high starts no transfer and changes nothing about the transfer in progress.
- R10: done is high for exactly one cycle, in the cycle in which the select returns high, and rx_data is valid in that cycle.
- R11: A write to the mode port stores the polarity and phase for the addressed target. Every later transfer to that target uses the stored mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for a target's mode |
| cfg_tgt | input | 2 | Target index for the mode write |
| cfg_cpol | input | 1 | Idle clock level to store |
| cfg_cpha | input | 1 | Phase to store: 0 samples on the first edge, 1 on the second |
| div_we | input | 1 | Write strobe for the divider |
| div_val | input | 8 | Divider value DIV |
| req_valid | input | 1 | Transfer request strobe |
| req_tgt | input | 2 | Target index of the request |
| req_len | input | 2 | Length code (see R6) |
| req_data | input | 32 | Transmit word, right-aligned |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the targets |
| miso | input | 1 | Serial data from the selected target |
| ss_n | output | 4 | Active-low select lines, one per target |

## Verification
The hardest case to reach is a change between two targets whose polarities differ. The clock must settle at the new idle level before the new select falls. The stimulus stores all four polarity and phase combinations, walks through the targets back to back, and then rewrites modes at random between transfers. Every change of polarity is therefore seen at a select edge. A bench-side target model reacts to the observed edges according to the mode the bench stored. Any error in the choice of edge or in bit order shows up as a mismatch in the word it captures, or in the word the master returns.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

    // Widest frame the shifter supports.
    localparam int unsigned WORD_W = 32;

    // Engine sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PREP  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } eng_state_e;

    // Stored mode of one target.
    typedef struct packed {
        logic cpol;
        logic cpha;
    } tgt_mode_t;

    // Length code to bit count: 00 -> 8, 01 -> 16, 1x -> 32.
    function automatic logic [5:0] frame_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 6'd8;
            2'b01:   return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/spi_mm_cfg.sv
// spi_mm_cfg: mode registers for the targets and the clock divider.
// Holds one polarity/phase pair per target and a single divider value.
// The mode of one target is read out combinationally by index.
// Assumes rd_tgt and cfg_tgt are always below N_TGT.
module spi_mm_cfg
    import spi_mm_pkg::*;
#(
    parameter int unsigned N_TGT     = 4,
    parameter int unsigned TW        = 2,
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned DIV_RESET = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [TW-1:0]    cfg_tgt,
    input  tgt_mode_t        cfg_mode,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    input  logic [TW-1:0]    rd_tgt,
    output tgt_mode_t        rd_mode,
    output logic [DIV_W-1:0] div_q
);

    tgt_mode_t slot_view [N_TGT];

    for (genvar g = 0; g < N_TGT; g++) begin : g_slot
        tgt_mode_t slot_q;

        // Store the mode written for this target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (cfg_we && cfg_tgt == TW'(g))
                slot_q <= cfg_mode;
        end

        assign slot_view[g] = slot_q;
    end

    // Store the divider value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= DIV_W'(DIV_RESET);
        else if (div_we)
            div_q <= div_val;
    end

    assign rd_mode = slot_view[rd_tgt];

    // R11
    mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !div_we) |=> (slot_view[$past(cfg_tgt)] == $past(cfg_mode)));

endmodule

// File: rtl/spi_mm_tick.sv
// spi_mm_tick: half-period tick generator for the serial clock.
// While en is high it emits one tick every div+1 cycles.
// It restarts from zero whenever en is low.
// Assumes div stays stable while en is high.
module spi_mm_tick #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    // Count system cycles within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R7
    half_period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q <= div));

    // R7
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en && $stable(div) && div != '0) |=> !tick);

endmodule

// File: rtl/spi_mm_engine.sv
// spi_mm_engine: transfer sequencer and shift datapath.
// On an accepted request it latches the target, length, mode and divider.
// It moves sclk to the idle level for one cycle, then asserts the select
// and toggles sclk on every tick. It shifts MSB first and samples miso.
// After a hold half-period it releases the select and pulses done.
// Assumes sel_mode is the stored mode of req_tgt in the same cycle.
module spi_mm_engine
    import spi_mm_pkg::*;
#(
    parameter int unsigned N_TGT = 4,
    parameter int unsigned TW    = 2,
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TW-1:0]     req_tgt,
    input  logic [1:0]        req_len,
    input  logic [WORD_W-1:0] req_data,
    input  tgt_mode_t         sel_mode,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              tick,
    output logic              tick_en,
    output logic [DIV_W-1:0]  lat_div,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [N_TGT-1:0]  ss_n
);

    localparam int unsigned EW = 7;

    eng_state_e        st;
    logic [TW-1:0]     lat_tgt;
    logic [5:0]        lat_bits;
    tgt_mode_t         lat_mode;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic [EW-1:0]     ecnt;
    logic              samp_edge;
    logic              drv_edge;
    logic              last_edge;
    logic              sel_live;

    // Choose, per edge, whether to sample or to drive.
    always_comb begin
        samp_edge = lat_mode.cpha ? ecnt[0] : ~ecnt[0];
        drv_edge  = lat_mode.cpha ? (~ecnt[0] && ecnt != '0) : ecnt[0];
        last_edge = (ecnt == ({1'b0, lat_bits} << 1) - 1'b1);
        sel_live  = (st == ST_SHIFT) || (st == ST_HOLD);
    end

    // Sequence the transfer and move the shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            lat_tgt  <= '0;
            lat_bits <= 6'd8;
            lat_mode <= '0;
            lat_div  <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            ecnt     <= '0;
            sclk     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        lat_tgt  <= req_tgt;
                        lat_bits <= frame_bits(req_len);
                        lat_mode <= sel_mode;
                        lat_div  <= div_cfg;
                        tx_sh    <= req_data << (6'd32 - frame_bits(req_len));
                        rx_sh    <= '0;
                        ecnt     <= '0;
                        sclk     <= sel_mode.cpol;
                        st       <= ST_PREP;
                    end
                end
                ST_PREP: st <= ST_SHIFT;
                ST_SHIFT: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        ecnt <= ecnt + 1'b1;
                        if (samp_edge)
                            rx_sh <= {rx_sh[WORD_W-2:0], miso};
                        if (drv_edge)
                            tx_sh <= tx_sh << 1;
                        if (last_edge)
                            st <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        rx_data <= rx_sh;
                        done    <= 1'b1;
                        st      <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (st != ST_IDLE);
    assign tick_en = sel_live;
    assign mosi    = tx_sh[WORD_W-1];

    for (genvar g = 0; g < N_TGT; g++) begin : g_sel
        assign ss_n[g] = !(sel_live && lat_tgt == TW'(g));
    end

    // R2
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ss_n));

    // R3
    idle_before_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&$past(ss_n)) && !(&ss_n)) |-> (sclk == lat_mode.cpol && $stable(sclk)));

    // R6
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT) |-> (ecnt < ({1'b0, lat_bits} << 1)));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(lat_tgt) && $stable(lat_bits) && $stable(lat_mode)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&ss_n && !busy));

endmodule

// File: rtl/spi_multi_master.sv
// spi_multi_master: top of the multi-target serial master.
// Connects the mode registers, the tick generator and the engine.
// The mode of the requested target is looked up in the cycle of the
// request. Assumes that targets drive miso only while selected.
module spi_multi_master
    import spi_mm_pkg::*;
#(
    parameter int unsigned N_TGT     = 4,
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned DIV_RESET = 1,
    localparam int unsigned TW       = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [TW-1:0]     cfg_tgt,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              req_valid,
    input  logic [TW-1:0]     req_tgt,
    input  logic [1:0]        req_len,
    input  logic [WORD_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [N_TGT-1:0]  ss_n
);

    tgt_mode_t        sel_mode;
    tgt_mode_t        wr_mode;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lat_div;
    logic             tick;
    logic             tick_en;

    assign wr_mode = '{cpol: cfg_cpol, cpha: cfg_cpha};

    spi_mm_cfg #(
        .N_TGT(N_TGT), .TW(TW), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_mode(wr_mode),
        .div_we(div_we), .div_val(div_val),
        .rd_tgt(req_tgt), .rd_mode(sel_mode), .div_q(div_q)
    );

    spi_mm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(tick_en), .div(lat_div), .tick(tick)
    );

    spi_mm_engine #(.N_TGT(N_TGT), .TW(TW), .DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tgt(req_tgt), .req_len(req_len),
        .req_data(req_data), .sel_mode(sel_mode), .div_cfg(div_q),
        .tick(tick), .tick_en(tick_en), .lat_div(lat_div),
        .busy(busy), .done(done), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

endmodule

// File: tb/spi_multi_master_test.sv
module spi_multi_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_tgt = '0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        div_we = 1'b0;
    logic [7:0]  div_val = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_tgt = '0;
    logic [1:0]  req_len = '0;
    logic [31:0] req_data = '0;
    logic        busy, done, sclk, mosi;
    logic [31:0] rx_data;
    logic        miso_r = 1'b0;
    logic [3:0]  ss_n;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench copy of stored modes and divider
    bit          b_cpol [4];
    bit          b_cpha [4];
    int          cur_div = 1;
    int          cur_len = 8;
    logic [31:0] slave_tx = '0;

    // monitor state
    logic [3:0]  m_prev_ss = '1;
    logic        m_prev_sclk = 1'b0;
    int          m_falls = 0, m_sel = 0, m_edges = 0, m_since = 0;
    int          m_setup = 0, m_hold = 0, m_idx = 0;
    bit          m_idle_lvl = 0, m_idle_stable = 0, m_bad_gap = 0, m_multi = 0, m_cpha = 0;
    logic [31:0] m_cap = '0;

    always #5 clk = ~clk;

    spi_multi_master uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .div_we(div_we), .div_val(div_val),
        .req_valid(req_valid), .req_tgt(req_tgt), .req_len(req_len), .req_data(req_data),
        .busy(busy), .done(done), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso_r), .ss_n(ss_n)
    );

    function automatic int len_of(input logic [1:0] code);
        return (code == 2'b00) ? 8 : (code == 2'b01) ? 16 : 32;
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Target model: follows sclk edges with the bench's stored mode.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_prev_ss   = '1;
            m_prev_sclk = sclk;
        end else begin
            if ((&m_prev_ss) && !(&ss_n)) begin
                m_falls++;
                for (int i = 0; i < 4; i++) if (!ss_n[i]) m_sel = i;
                m_idle_lvl    = sclk;
                m_idle_stable = (sclk == m_prev_sclk);
                m_edges = 0; m_since = 0; m_bad_gap = 0; m_cap = '0;
                m_idx  = cur_len - 1;
                m_cpha = b_cpha[m_sel];
                if (!m_cpha) begin miso_r = slave_tx[m_idx]; m_idx--; end
            end else if (!(&ss_n)) begin
                m_since++;
                if (sclk != m_prev_sclk) begin
                    bit lead;
                    if (m_edges == 0) m_setup = m_since;
                    else if (m_since != cur_div + 1) m_bad_gap = 1;
                    m_since = 0;
                    lead = (m_edges % 2 == 0);
                    if (m_cpha ? !lead : lead) m_cap = {m_cap[30:0], mosi};
                    if ((m_cpha ? lead : !lead) && m_idx >= 0) begin
                        miso_r = slave_tx[m_idx]; m_idx--;
                    end
                    m_edges++;
                end
            end else if (!(&m_prev_ss)) begin
                m_hold = m_since + 1;
            end
            if ($countones(~ss_n) > 1) m_multi = 1;
            m_prev_ss   = ss_n;
            m_prev_sclk = sclk;
        end
    end

    task automatic set_mode(input int t, input bit pol, input bit pha);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tgt = 2'(t); cfg_cpol = pol; cfg_cpha = pha;
        @(negedge clk);
        cfg_we = 1'b0;
        b_cpol[t] = pol; b_cpha[t] = pha;
    endtask

    task automatic set_div(input int d);
        @(negedge clk);
        div_we = 1'b1; div_val = 8'(d);
        @(negedge clk);
        div_we = 1'b0;
        cur_div = d;
    endtask

    task automatic xfer(input int t, input logic [1:0] lc, input logic [31:0] data,
                        input logic [31:0] stx, input bit spam);
        int L;
        int falls0;
        logic [31:0] got;
        L = len_of(lc);
        cur_len = L; slave_tx = stx; falls0 = m_falls;
        @(negedge clk);
        req_valid = 1'b1; req_tgt = 2'(t); req_len = lc; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", {31'b0, busy}, 32'h1);
        if (spam) begin
            repeat (3) begin
                @(negedge clk);
                req_valid = 1'b1; req_tgt = 2'(t + 1); req_len = ~lc; req_data = ~data;
            end
            @(negedge clk);
            req_valid = 1'b0;
        end
        do @(negedge clk); while (!done);
        got = rx_data;
        chk(&ss_n, "R10 select released with done", {28'b0, ss_n}, 32'hF);
        @(negedge clk);
        chk(!done, "R10 done one cycle", {31'b0, done}, 32'h0);
        chk(got == (stx & mask_of(L)), "R5 received word", got, stx & mask_of(L));
        chk(m_cap == (data & mask_of(L)), "R4 R5 word seen on mosi", m_cap, data & mask_of(L));
        chk(m_edges == 2 * L, "R6 edge count", m_edges, 2 * L);
        chk(!m_bad_gap, "R7 half period", {31'b0, m_bad_gap}, 32'h0);
        chk(m_setup == cur_div + 1, "R8 setup", m_setup, cur_div + 1);
        chk(m_hold == cur_div + 1, "R8 hold", m_hold, cur_div + 1);
        chk(m_idle_lvl == b_cpol[t] && m_idle_stable, "R3 idle level at select",
            {31'b0, m_idle_lvl}, {31'b0, b_cpol[t]});
        chk(m_falls - falls0 == 1 && m_sel == t && !m_multi, "R2 single select",
            m_sel, t);
        if (spam) begin
            repeat (2 * cur_div + 8) @(negedge clk);
            chk(!busy && (&ss_n) && m_falls - falls0 == 1, "R9 busy request ignored",
                {27'b0, busy, ss_n}, 32'hF);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1F2E3D4C);
        for (int i = 0; i < 4; i++) begin b_cpol[i] = 0; b_cpha[i] = 0; end
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ss_n == 4'hF && !busy && !done && !sclk && !mosi && rx_data == '0,
            "R1 reset state", {25'b0, ss_n, busy, done, sclk}, 32'h78);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ss_n == 4'hF && !busy, "R1 idle after reset", {27'b0, busy, ss_n}, 32'hF);

        // R11 all four modes, walk targets back to back
        set_div(0);
        set_mode(0, 0, 0);
        set_mode(1, 0, 1);
        set_mode(2, 1, 0);
        set_mode(3, 1, 1);
        for (int t = 0; t < 4; t++)
            for (int lc = 0; lc < 3; lc++)
                xfer(t, 2'(lc), 32'hA5C3_0F96 ^ (32'h1111_1111 * t), 32'h5A3C_F069 + lc, 0);
        // corner words
        xfer(2, 2'b10, 32'hFFFF_FFFF, 32'h0000_0000, 0);
        xfer(1, 2'b10, 32'h8000_0001, 32'h8000_0001, 0);
        xfer(3, 2'b00, 32'h0000_0080, 32'h0000_0001, 0);
        // wider divider, R6 code 11 means 32 bits
        set_div(3);
        xfer(0, 2'b11, 32'hDEAD_BEEF, 32'hCAFE_F00D, 0);
        xfer(2, 2'b01, 32'h0000_1234, 32'h0000_ABCD, 0);
        // R9 requests during busy are dropped
        xfer(3, 2'b00, 32'h0000_00C3, 32'h0000_003C, 1);
        // R11 rewrite one target's mode and use it
        set_mode(2, 0, 1);
        xfer(2, 2'b00, 32'h0000_0096, 32'h0000_0069, 0);
        set_mode(2, 1, 1);
        xfer(2, 2'b01, 32'h0000_F00F, 32'h0000_0FF0, 0);

        // constrained random traffic
        for (int k = 0; k < 30; k++) begin
            if (k % 5 == 0) set_div(int'($urandom % 4));
            if (k % 3 == 0) set_mode(int'($urandom % 4), 1'($urandom), 1'($urandom));
            xfer(int'($urandom % 4), 2'($urandom), $urandom, $urandom, (k % 7 == 3));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule